// File: doc/BRIEF.md
# I/O Port Slice with Peripheral Override Muxes

This block is one slice of a general-purpose I/O port. Software owns two registers per slice, an output-level register and a direction register, and a chip-wide pull-up kill bit arrives as an input. Between each pin's register-derived controls and the pad sit four override muxes: pull-up, direction, drive level and digital-input enable. Each mux is steered by an enable/value pair. That pair comes from the mode bits of the peripherals sharing the pin.

Pin roles are fixed by index:
- Pin 0 is shared by a UART receiver and an SPI clock on the alternate pin set.
- Pin 1 is the SPI slave-out pin of that alternate set.
- Pin 2 can carry a divided system clock.
- Pin 3 carries an external interrupt together with an analog channel.
- Every higher pin is analog-plus-digital only.

Software reads back both registers and a two-stage synchronized copy of the digital inputs. The same gated digital inputs also go straight to the peripherals.

Top module: `gpioPortOvr`

## Requirements
- R1: During and after reset the output-level and direction registers read 0. Every pin except pin 2 is an undriven input with no pull-up, and the synchronized pin readback is 0.
- R2: With no override active, `padOe[i]` equals direction bit i and `padOut[i]` equals level bit i. A write with `wrSel`=0 loads the level register and `wrSel`=1 loads the direction register. The registers are read back with `rdSel` 0 and 1 respectively.
- R3: With no pull-up override, `padPullUp[i]` is 1 exactly when the direction bit is 0, the level bit is 1 and `pullDisable` is 0.
- R4: Pin 0 is forced to input when `uartRxEn` is 1, or when `spiEn`, `spiMaster` and `spiAltSel` are all 1. While forced, its pull-up is the level bit AND NOT `pullDisable`.
- R5: When `spiEn`, `spiMaster` and `spiAltSel` are all 1, `padOut[0]` equals `spiSckOut` instead of the level bit.
- R6: Pin 1 is forced to input when SPI is master on the alternate set, and its pull-up is then the level bit AND NOT `pullDisable`. When SPI is slave on the alternate set, its direction follows its direction bit and `padOut[1]` equals `spiMisoOut`.
- R7: When `clkOutFuse` is 1 or `rstN` is 0, pin 2 is an output driving `divClk` with no pull-up, regardless of its register bits.
- R8: On pin 3 the digital input is enabled when `intEn` is 1, even if `adcDis[0]` is 1. It is disabled only when `adcDis[0]` is 1 and `intEn` is 0.
- R9: For each pin k of 4 and above, `adcDis[k-3]` = 1 forces `digIn[k]` to 0. All other controls of those pins follow the registers.
- R10: `padPullUp[i]` is never 1 while `padOe[i]` is 1.
- R11: With `rdSel`=2, `rdData` shows `digIn` as sampled two clock edges earlier, where a disabled input reads 0.
- R12: A write with `wrSel`=2 or 3 changes neither register. A read with `rdSel`=3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Write target: 0 level, 1 direction |
| wrData | input | NUM_PINS | Write data |
| rdSel | input | 2 | Read source: 0 level, 1 direction, 2 synchronized pins |
| rdData | output | NUM_PINS | Read data |
| pullDisable | input | 1 | Chip-wide pull-up kill |
| uartRxEn | input | 1 | UART receiver enabled |
| spiEn | input | 1 | SPI enabled |
| spiMaster | input | 1 | SPI in master mode |
| spiAltSel | input | 1 | SPI routed to this alternate pin set |
| spiSckOut | input | 1 | SPI master clock to drive |
| spiMisoOut | input | 1 | SPI slave data to drive |
| clkOutFuse | input | 1 | Clock-output fuse programmed |
| divClk | input | 1 | Divided system clock |
| intEn | input | 1 | External interrupt enabled on pin 3 |
| adcDis | input | NUM_ADC | Analog digital-input disables, pins 3 and up |
| padIn | input | NUM_PINS | Pad input levels |
| padOe | output | NUM_PINS | Pad output enable |
| padOut | output | NUM_PINS | Pad drive level |
| padPullUp | output | NUM_PINS | Pad pull-up enable |
| digIn | output | NUM_PINS | Gated digital inputs to peripherals |

## Verification
The override controls are combinational, so a wrong enable or value shows on the pad outputs in the same cycle as the mode change. A single mode bit can hit several pins at once. Sweeping all mode-bit combinations against an independent per-pin model therefore exposes a swapped or missing term right away. A register corrupted by a write to the wrong target shows at the next read or on the pad in the following cycle. A synchronizer that is too short or too long shows as readback one edge early or one edge late.

// File: rtl/gpioOvrPkg.sv
package gpioOvrPkg;

  typedef struct packed {
    logic puOe;
    logic puOv;
    logic dirOe;
    logic dirOv;
    logic valOe;
    logic valOv;
    logic ieOe;
    logic ieOv;
  } pinOvr_t;

  typedef enum logic [1:0] {
    SEL_LEVEL = 2'd0,
    SEL_DIR   = 2'd1,
    SEL_PINS  = 2'd2,
    SEL_NONE  = 2'd3
  } regSel_e;

  localparam int PIN_SCK      = 0;
  localparam int PIN_MISO     = 1;
  localparam int PIN_CLKO     = 2;
  localparam int PIN_INT      = 3;
  localparam int FIRST_ANALOG = 4;

endpackage

// File: rtl/gpioOvrCtl.sv
module gpioOvrCtl
  import gpioOvrPkg::*;
#(
  parameter int NUM_PINS = 6,
  localparam int NUM_ADC = NUM_PINS - PIN_INT
) (
  input  logic                rstActive,
  input  logic                pullDisable,
  input  logic                levelSck,
  input  logic                levelMiso,
  input  logic                uartRxEn,
  input  logic                spiEn,
  input  logic                spiMaster,
  input  logic                spiAltSel,
  input  logic                spiSckOut,
  input  logic                spiMisoOut,
  input  logic                clkOutFuse,
  input  logic                divClk,
  input  logic                intEn,
  input  logic [NUM_ADC-1:0]  adcDis,
  output pinOvr_t [NUM_PINS-1:0] ovr
);

  logic spiMasterAlt;
  logic spiSlaveAlt;
  logic sckForceIn;
  logic clkDrive;

  assign spiMasterAlt = spiEn & spiMaster & spiAltSel;
  assign spiSlaveAlt  = spiEn & ~spiMaster & spiAltSel;
  assign sckForceIn   = uartRxEn | spiMasterAlt;
  assign clkDrive     = clkOutFuse | rstActive;

  always_comb begin
    for (int p = 0; p < NUM_PINS; p++) begin
      ovr[p] = '0;
    end

    // shared receive / SPI clock pin
    ovr[PIN_SCK].puOe  = sckForceIn;
    ovr[PIN_SCK].puOv  = levelSck & ~pullDisable;
    ovr[PIN_SCK].dirOe = sckForceIn;
    ovr[PIN_SCK].dirOv = 1'b0;
    ovr[PIN_SCK].valOe = spiMasterAlt;
    ovr[PIN_SCK].valOv = spiSckOut;

    // SPI slave-out pin
    ovr[PIN_MISO].puOe  = spiMasterAlt;
    ovr[PIN_MISO].puOv  = levelMiso & ~pullDisable;
    ovr[PIN_MISO].dirOe = spiMasterAlt;
    ovr[PIN_MISO].dirOv = 1'b0;
    ovr[PIN_MISO].valOe = spiSlaveAlt;
    ovr[PIN_MISO].valOv = spiMisoOut;

    // divided clock output pin
    ovr[PIN_CLKO].puOe  = clkDrive;
    ovr[PIN_CLKO].puOv  = 1'b0;
    ovr[PIN_CLKO].dirOe = clkDrive;
    ovr[PIN_CLKO].dirOv = 1'b1;
    ovr[PIN_CLKO].valOe = clkDrive;
    ovr[PIN_CLKO].valOv = divClk;

    // interrupt + analog pin: interrupt keeps the input alive
    ovr[PIN_INT].ieOe = adcDis[0] | intEn;
    ovr[PIN_INT].ieOv = intEn;

    // analog-only pins
    for (int k = FIRST_ANALOG; k < NUM_PINS; k++) begin
      ovr[k].ieOe = adcDis[k - PIN_INT];
      ovr[k].ieOv = 1'b0;
    end
  end

endmodule

// File: rtl/gpioPortDp.sv
module gpioPortDp
  import gpioOvrPkg::*;
#(
  parameter int NUM_PINS = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [1:0]             wrSel,
  input  logic [NUM_PINS-1:0]    wrData,
  input  logic [1:0]             rdSel,
  output logic [NUM_PINS-1:0]    rdData,
  input  logic                   pullDisable,
  input  pinOvr_t [NUM_PINS-1:0] ovr,
  input  logic [NUM_PINS-1:0]    padIn,
  output logic [NUM_PINS-1:0]    padOe,
  output logic [NUM_PINS-1:0]    padOut,
  output logic [NUM_PINS-1:0]    padPullUp,
  output logic [NUM_PINS-1:0]    digIn,
  output logic [NUM_PINS-1:0]    levelReg
);

  logic [NUM_PINS-1:0] dirReg;
  logic [NUM_PINS-1:0] syncPipe [SYNC_STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelReg <= '0;
      dirReg   <= '0;
    end else if (wrEn) begin
      if (wrSel == SEL_LEVEL) levelReg <= wrData;
      if (wrSel == SEL_DIR)   dirReg   <= wrData;
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : gPin
    logic puNorm;
    logic dirFin;
    logic valFin;
    logic puFin;
    logic ieFin;

    assign puNorm = levelReg[i] & ~dirReg[i] & ~pullDisable;
    assign dirFin = ovr[i].dirOe ? ovr[i].dirOv : dirReg[i];
    assign valFin = ovr[i].valOe ? ovr[i].valOv : levelReg[i];
    assign puFin  = ovr[i].puOe  ? ovr[i].puOv  : puNorm;
    assign ieFin  = ovr[i].ieOe  ? ovr[i].ieOv  : 1'b1;

    assign padOe[i]     = dirFin;
    assign padOut[i]    = valFin;
    assign padPullUp[i] = puFin & ~dirFin;
    assign digIn[i]     = padIn[i] & ieFin;
  end

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncPipe[s] <= '0;
      end else if (s == 0) begin
        syncPipe[s] <= digIn;
      end else begin
        syncPipe[s] <= syncPipe[(s == 0) ? 0 : s - 1];
      end
    end
  end

  always_comb begin
    unique case (rdSel)
      SEL_LEVEL: rdData = levelReg;
      SEL_DIR:   rdData = dirReg;
      SEL_PINS:  rdData = syncPipe[SYNC_STAGES-1];
      default:   rdData = '0;
    endcase
  end

endmodule

// File: rtl/gpioPortOvr.sv
module gpioPortOvr
  import gpioOvrPkg::*;
#(
  parameter int NUM_PINS = 6,
  localparam int NUM_ADC = NUM_PINS - PIN_INT
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [1:0]          wrSel,
  input  logic [NUM_PINS-1:0] wrData,
  input  logic [1:0]          rdSel,
  output logic [NUM_PINS-1:0] rdData,
  input  logic                pullDisable,
  input  logic                uartRxEn,
  input  logic                spiEn,
  input  logic                spiMaster,
  input  logic                spiAltSel,
  input  logic                spiSckOut,
  input  logic                spiMisoOut,
  input  logic                clkOutFuse,
  input  logic                divClk,
  input  logic                intEn,
  input  logic [NUM_ADC-1:0]  adcDis,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padPullUp,
  output logic [NUM_PINS-1:0] digIn
);

  pinOvr_t [NUM_PINS-1:0] ovr;
  logic [NUM_PINS-1:0]    levelReg;

  gpioOvrCtl #(.NUM_PINS(NUM_PINS)) uCtl (
    .rstActive   (~rstN),
    .pullDisable (pullDisable),
    .levelSck    (levelReg[PIN_SCK]),
    .levelMiso   (levelReg[PIN_MISO]),
    .uartRxEn    (uartRxEn),
    .spiEn       (spiEn),
    .spiMaster   (spiMaster),
    .spiAltSel   (spiAltSel),
    .spiSckOut   (spiSckOut),
    .spiMisoOut  (spiMisoOut),
    .clkOutFuse  (clkOutFuse),
    .divClk      (divClk),
    .intEn       (intEn),
    .adcDis      (adcDis),
    .ovr         (ovr)
  );

  gpioPortDp #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(2)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .wrEn        (wrEn),
    .wrSel       (wrSel),
    .wrData      (wrData),
    .rdSel       (rdSel),
    .rdData      (rdData),
    .pullDisable (pullDisable),
    .ovr         (ovr),
    .padIn       (padIn),
    .padOe       (padOe),
    .padOut      (padOut),
    .padPullUp   (padPullUp),
    .digIn       (digIn),
    .levelReg    (levelReg)
  );

endmodule

// File: rtl/gpioPortOvr_chk.sv
module gpioPortOvr_chk #(
  parameter int NUM_PINS = 6,
  parameter int NUM_ADC  = 3
) (
  input logic                clk,
  input logic                rstN,
  input logic                uartRxEn,
  input logic                spiEn,
  input logic                spiMaster,
  input logic                spiAltSel,
  input logic                clkOutFuse,
  input logic                divClk,
  input logic                intEn,
  input logic [NUM_ADC-1:0]  adcDis,
  input logic [NUM_PINS-1:0] padIn,
  input logic [NUM_PINS-1:0] padOe,
  input logic [NUM_PINS-1:0] padOut,
  input logic [NUM_PINS-1:0] padPullUp,
  input logic [NUM_PINS-1:0] digIn
);

  logic masterAlt;
  assign masterAlt = spiEn & spiMaster & spiAltSel;

  AST_PULL_NOT_DRIVING: assert property (@(posedge clk) disable iff (!rstN)
    (padPullUp & padOe) == '0); // R10

  AST_SCK_PIN_INPUT: assert property (@(posedge clk) disable iff (!rstN)
    (uartRxEn || masterAlt) |-> !padOe[0]); // R4

  AST_MISO_MASTER_INPUT: assert property (@(posedge clk) disable iff (!rstN)
    masterAlt |-> !padOe[1]); // R6

  AST_CLKO_FUSE_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    clkOutFuse |-> (padOe[2] && padOut[2] == divClk && !padPullUp[2])); // R7

  AST_INT_INPUT_ALIVE: assert property (@(posedge clk) disable iff (!rstN)
    intEn |-> (digIn[3] == padIn[3])); // R8

  AST_ANALOG_INPUT_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (digIn[NUM_PINS-1:4] & adcDis[NUM_ADC-1:1]) == '0); // R9

  always @(negedge clk) begin
    if (rstN === 1'b0) begin
      AST_CLKO_RESET_DRIVE: assert (padOe[2] && padOut[2] == divClk); // R7
    end
  end

endmodule

bind gpioPortOvr gpioPortOvr_chk #(.NUM_PINS(NUM_PINS), .NUM_ADC(NUM_ADC)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .uartRxEn   (uartRxEn),
  .spiEn      (spiEn),
  .spiMaster  (spiMaster),
  .spiAltSel  (spiAltSel),
  .clkOutFuse (clkOutFuse),
  .divClk     (divClk),
  .intEn      (intEn),
  .adcDis     (adcDis),
  .padIn      (padIn),
  .padOe      (padOe),
  .padOut     (padOut),
  .padPullUp  (padPullUp),
  .digIn      (digIn)
);

// File: tb/gpioPortOvr_test.sv
module gpioPortOvr_test;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 6;
  localparam int NA = N - 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrSel = '0;
  logic [N-1:0] wrData = '0;
  logic [1:0] rdSel = '0;
  logic [N-1:0] rdData;
  logic pullDisable = 1'b0;
  logic uartRxEn = 1'b0, spiEn = 1'b0, spiMaster = 1'b0, spiAltSel = 1'b0;
  logic spiSckOut = 1'b0, spiMisoOut = 1'b0, clkOutFuse = 1'b0, divClk = 1'b0;
  logic intEn = 1'b0;
  logic [NA-1:0] adcDis = '0;
  logic [N-1:0] padIn = '0;
  logic [N-1:0] padOe, padOut, padPullUp, digIn;

  logic [N-1:0] mLevel = '0, mDir = '0;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpioPortOvr #(.NUM_PINS(N)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdData), .pullDisable(pullDisable),
    .uartRxEn(uartRxEn), .spiEn(spiEn), .spiMaster(spiMaster),
    .spiAltSel(spiAltSel), .spiSckOut(spiSckOut), .spiMisoOut(spiMisoOut),
    .clkOutFuse(clkOutFuse), .divClk(divClk), .intEn(intEn), .adcDis(adcDis),
    .padIn(padIn), .padOe(padOe), .padOut(padOut), .padPullUp(padPullUp),
    .digIn(digIn)
  );

  // Expected pad controls, built pin by pin from the requirements
  function automatic void expPads(output logic [N-1:0] eOe, output logic [N-1:0] eOut,
                                  output logic [N-1:0] ePu, output logic [N-1:0] eDig);
    logic [N-1:0] ie;
    logic mAlt, sAlt;
    mAlt = spiEn & spiMaster & spiAltSel;
    sAlt = spiEn & ~spiMaster & spiAltSel;
    ie = '1;
    for (int i = 0; i < N; i++) begin
      eOe[i]  = mDir[i];
      eOut[i] = mLevel[i];
      ePu[i]  = mLevel[i] & ~mDir[i] & ~pullDisable;
    end
    if (uartRxEn || mAlt) begin eOe[0] = 1'b0; ePu[0] = mLevel[0] & ~pullDisable; end
    if (mAlt) eOut[0] = spiSckOut;
    if (mAlt) begin eOe[1] = 1'b0; ePu[1] = mLevel[1] & ~pullDisable; end
    if (sAlt) eOut[1] = spiMisoOut;
    if (clkOutFuse || !rstN) begin eOe[2] = 1'b1; eOut[2] = divClk; ePu[2] = 1'b0; end
    if (adcDis[0] || intEn) ie[3] = intEn;
    for (int k = 4; k < N; k++) if (adcDis[k-3]) ie[k] = 1'b0;
    ePu  = ePu & ~eOe;
    eDig = padIn & ie;
  endfunction

  task automatic checkPads(input string tag);
    logic [N-1:0] eOe, eOut, ePu, eDig;
    expPads(eOe, eOut, ePu, eDig);
    checks++;
    if (padOe !== eOe || padOut !== eOut || padPullUp !== ePu || digIn !== eDig) begin
      fails++;
      $display("FAIL %s: oe/out/pu/dig got %b %b %b %b expected %b %b %b %b",
               tag, padOe, padOut, padPullUp, digIn, eOe, eOut, ePu, eDig);
    end
  endtask

  task automatic checkVal(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] sel, input logic [N-1:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
    if (sel == 2'd0) mLevel = data;
    if (sel == 2'd1) mDir = data;
  endtask

  task automatic clearModes();
    uartRxEn = 0; spiEn = 0; spiMaster = 0; spiAltSel = 0;
    clkOutFuse = 0; intEn = 0; adcDis = '0; pullDisable = 0;
  endtask

  initial begin
    void'($urandom(32'hC0FFEE));

    // R1 / R7: reset state and clock drive during reset
    divClk = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    checkPads("R7 clock pin driven in reset");
    checkVal("R1 reset oe", padOe & ~6'b000100, '0);
    checkVal("R1 reset pull-up", padPullUp, '0);
    rdSel = 2'd0; #1 checkVal("R1 reset level reg", rdData, '0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    rdSel = 2'd1; #1 checkVal("R1 dir reg after reset", rdData, '0);
    rdSel = 2'd2; #1 checkVal("R1 sync readback after reset", rdData, '0);
    checkVal("R1 clock pin released", padOe, '0);

    // R2 register writes and normal paths
    writeReg(2'd0, 6'b101101);
    writeReg(2'd1, 6'b110010);
    #1;
    rdSel = 2'd0; #1 checkVal("R2 level readback", rdData, 6'b101101);
    rdSel = 2'd1; #1 checkVal("R2 dir readback", rdData, 6'b110010);
    checkPads("R2 normal drive");

    // R12 ignored write targets and empty read
    writeReg(2'd2, 6'b010101);
    writeReg(2'd3, 6'b011011);
    #1;
    rdSel = 2'd0; #1 checkVal("R12 level untouched", rdData, 6'b101101);
    rdSel = 2'd1; #1 checkVal("R12 dir untouched", rdData, 6'b110010);
    rdSel = 2'd3; #1 checkVal("R12 empty read", rdData, '0);

    // R3 pull-up under normal control
    writeReg(2'd1, 6'b000000);
    writeReg(2'd0, 6'b111111);
    #1 checkVal("R3 pull-ups on", padPullUp, 6'b111111);
    pullDisable = 1'b1;
    #1 checkVal("R3 pull-up kill", padPullUp, '0);
    pullDisable = 1'b0;

    // R4 / R5 / R6 directed: SPI master on alternate set with outputs requested
    writeReg(2'd1, 6'b111111);
    spiEn = 1; spiMaster = 1; spiAltSel = 1; spiSckOut = 1'b0;
    #1 checkVal("R4 sck pin forced input", padOe[1:0], 2'b00);
    checkVal("R5 sck drive value", {5'b0, padOut[0]}, 6'b0);
    checkPads("R6 miso master forced input");
    spiMaster = 0; spiMisoOut = 1'b0;
    #1 checkVal("R6 miso slave follows dir", {5'b0, padOe[1]}, 6'b1);
    checkPads("R6 miso slave drives data");
    clearModes();

    // R8 interrupt keeps input alive; R9 analog disable
    padIn = '1;
    adcDis = '1; intEn = 1;
    #1 checkVal("R8 int input alive", digIn, 6'b001111);
    intEn = 0;
    #1 checkVal("R8/R9 inputs disabled", digIn, 6'b000111);
    clearModes();

    // R11 synchronizer latency
    padIn = '0;
    repeat (3) @(negedge clk);
    rdSel = 2'd2;
    padIn = 6'b101011;
    @(posedge clk); #2 checkVal("R11 one edge: not yet", rdData, '0);
    @(posedge clk); #2 checkVal("R11 two edges: visible", rdData, 6'b101011);
    @(negedge clk); adcDis = '1;
    @(posedge clk); @(posedge clk); #2
    checkVal("R11 disabled inputs read 0", rdData, 6'b000011);
    clearModes();

    // Sweep every mode-bit combination (R2 R3 R4 R5 R6 R7 R8 R9 R10)
    for (int m = 0; m < 512; m++) begin
      @(negedge clk);
      {uartRxEn, spiEn, spiMaster, spiAltSel, clkOutFuse, intEn, adcDis} = m[8:0];
      wrEn = 1'b1; wrSel = 2'($urandom_range(0, 1)); wrData = N'($urandom);
      @(negedge clk);
      wrEn = 1'b0;
      if (wrSel == 2'd0) mLevel = wrData; else mDir = wrData;
      pullDisable = 1'($urandom); padIn = N'($urandom);
      spiSckOut = 1'($urandom); spiMisoOut = 1'($urandom); divClk = 1'($urandom);
      #1 checkPads("R2 R3 R4 R5 R6 R7 R8 R9 R10 mode sweep");
    end

    // Random mixed stimulus
    for (int r = 0; r < 400; r++) begin
      @(negedge clk);
      {uartRxEn, spiEn, spiMaster, spiAltSel, clkOutFuse, intEn} = 6'($urandom);
      adcDis = NA'($urandom); pullDisable = 1'($urandom); padIn = N'($urandom);
      spiSckOut = 1'($urandom); spiMisoOut = 1'($urandom); divClk = 1'($urandom);
      #1 checkPads("R10 random mix");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule